// File: doc/BRIEF.md
# Byte-Bus Bridge for a 16-bit Timer with Shared High-Byte Latch

This block connects an 8-bit processor data bus to a timer whose counter and compare/capture register can each run as one 16-bit quantity. With the width-select input high, the counter's two bytes form a single 16-bit counter, and the A and B bytes form a single 16-bit compare or capture register. Each 16-bit transfer takes two byte accesses. One shared byte latch holds the high byte, so every transfer still lands, or is sampled, in a single clock cycle. With width-select low, every byte is an ordinary 8-bit register and the latch is left alone.

The timer has two modes. In compare mode it counts up on each prescaled tick and returns to zero on the tick after it reaches the compare value, and that tick raises a match flag. In capture mode it counts freely and wraps. A capture event copies the counter into the A/B pair and raises a capture flag. Both flags are cleared by writing a one to their bit.

The register map (3-bit byte address) is: 0 counter low byte, 1 counter high byte, 2 pair low byte (A), 3 pair high byte (B), 4 flags (bit 0 match, bit 1 capture). Software writes the high byte before the low byte, and reads the low byte before the high byte.

Top module: `tmr16_bridge`

## Requirements
- R1: After reset the counter, the A/B pair, the shared latch and both flags are zero, and every address reads 0x00. Read data is 0x00 whenever the read strobe is low.
- R2: In wide mode, a write to address 1 or 3 changes only the shared latch. The counter and the pair keep their values.
- R3: In wide mode, a write to address 0 loads the counter with the latch as the high byte and the written data as the low byte, in one cycle.
- R4: In wide mode, a read of address 0 returns the counter low byte and stores the counter high byte in the latch at that clock edge. A read of address 1 returns the latch, even if the counter has changed since.
- R5: One latch serves both registers. A high byte written at address 3 becomes the counter high byte on a following write to address 0.
- R6: In wide compare mode, a read of address 3 returns B directly and ignores the latch. A read of address 2 leaves the latch unchanged.
- R7: In capture mode, a capture event copies the counter into the pair (the whole 16 bits in wide mode, the low byte into A in narrow mode) and sets flag bit 1. In wide mode, a read of address 2 stores B in the latch, and a read of address 3 returns the latch.
- R8: The counter changes only on a tick or a bus write. In compare mode, a tick that finds the counter equal to the compare value sets the counter to zero and sets flag bit 0. Any other tick adds one.
- R9: A set flag stays set until a write to address 4 with a one in its bit position. Writing a zero there has no effect.
- R10: A counter write in the same cycle as a tick wins. The counter takes the written value and no increment occurs.
- R11: In narrow mode, each byte address reads and writes its own byte directly. Only the counter low byte counts, and it clears against A. The high byte holds its value, and the latch is neither written nor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Byte register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational from address |
| wide_sel | input | 1 | 1 selects 16-bit registers |
| cap_mode | input | 1 | 1 selects capture mode, 0 compare mode |
| cap_evt | input | 1 | Capture event pulse |
| tick | input | 1 | Prescaled count enable |

## Verification
The bench stages a high byte and then reads the counter low byte before finishing the write. A design that wrote high bytes straight into the counter would return the staged byte instead of the latched counter byte. It reads the high byte after a tick has carried into it. A design that read live data would show the new high byte, not the byte frozen by the low read. Compare-mode reads of address 3 are made while the latch holds a different value, which exposes any design that routes them through the latch. Capture-mode reads of address 3 are made after the latch has been reloaded, which exposes any design that skips the latch. The remaining directed cases are:
- a tick colliding with a counter write;
- the tick exactly at the compare value;
- a zero written to the flags;
- a narrow-mode run followed by a wide read of the untouched latch.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CNT_LO  = 3'd0,
        ADDR_CNT_HI  = 3'd1,
        ADDR_PAIR_LO = 3'd2,
        ADDR_PAIR_HI = 3'd3,
        ADDR_FLAGS   = 3'd4
    } reg_addr_e;

    localparam int FLAG_MATCH = 0;
    localparam int FLAG_CAPT  = 1;
    localparam int FLAG_N     = 2;
endpackage

// File: rtl/tmr16_tempreg.sv
module tmr16_tempreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] temp_o
);
    logic [DW-1:0] temp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       temp_q <= '0;
        else if (load_en) temp_q <= load_val;
    end

    assign temp_o = temp_q;

    // R2
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(temp_q));
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide,
    input  logic            cmp_mode,
    input  logic            tick,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic [2*DW-1:0] ld_val,
    input  logic [2*DW-1:0] top,
    output logic [2*DW-1:0] cnt_o,
    output logic            match_o
);
    localparam int WW = 2 * DW;

    logic [WW-1:0] cnt_q, cnt_d;
    logic          hit, ld_any;

    always_comb begin
        ld_any  = ld_lo | ld_hi;
        hit     = wide ? (cnt_q == top) : (cnt_q[DW-1:0] == top[DW-1:0]);
        match_o = tick && cmp_mode && hit && !ld_any;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (ld_any) begin
            if (ld_lo) cnt_d[DW-1:0]  = ld_val[DW-1:0];
            if (ld_hi) cnt_d[WW-1:DW] = ld_val[WW-1:DW];
        end else if (tick) begin
            if (wide) cnt_d = match_o ? '0 : cnt_q + 1'b1;
            else      cnt_d[DW-1:0] = match_o ? '0 : cnt_q[DW-1:0] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R8
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_lo && !ld_hi) |=> $stable(cnt_q));

    // R8
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> (cnt_q[DW-1:0] == '0));

    // R10
    cnt_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && tick) |=> (cnt_q[DW-1:0] == $past(ld_val[DW-1:0])));

    // R11
    cnt_narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !ld_hi) |=> $stable(cnt_q[WW-1:DW]));
endmodule

// File: rtl/tmr16_pair.sv
module tmr16_pair #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide,
    input  logic            cap_mode,
    input  logic            cap_evt,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic [2*DW-1:0] ld_val,
    input  logic [2*DW-1:0] cnt,
    output logic [2*DW-1:0] pair_o,
    output logic            capt_o
);
    localparam int WW = 2 * DW;

    logic [WW-1:0] pair_q, pair_d;

    always_comb begin
        capt_o = cap_mode && cap_evt;
        pair_d = pair_q;
        if (capt_o) begin
            if (wide) pair_d = cnt;
            else      pair_d[DW-1:0] = cnt[DW-1:0];
        end else begin
            if (ld_lo) pair_d[DW-1:0]  = ld_val[DW-1:0];
            if (ld_hi) pair_d[WW-1:DW] = ld_val[WW-1:DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign pair_o = pair_q;

    // R7
    pair_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_o && wide) |=> (pair_q == $past(cnt)));
endmodule

// File: rtl/tmr16_bridge.sv
module tmr16_bridge #(
    parameter int DW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [tmr16_pkg::ADDR_W-1:0] addr,
    input  logic [DW-1:0]                wdata,
    input  logic                         wr_en,
    input  logic                         rd_en,
    output logic [DW-1:0]                rdata,
    input  logic                         wide_sel,
    input  logic                         cap_mode,
    input  logic                         cap_evt,
    input  logic                         tick
);
    import tmr16_pkg::*;

    localparam int WW = 2 * DW;

    logic [WW-1:0]     cnt, pair, cnt_ld_val, pair_ld_val;
    logic [DW-1:0]     temp, temp_val, rd_mux;
    logic              match, capt;
    logic              wr_c_lo, wr_c_hi, wr_p_lo, wr_p_hi, wr_flg;
    logic              c_ld_lo, c_ld_hi, p_ld_lo, p_ld_hi, temp_ld;
    logic [FLAG_N-1:0] flags_q, flags_set;

    always_comb begin
        wr_c_lo = wr_en && (addr == ADDR_CNT_LO);
        wr_c_hi = wr_en && (addr == ADDR_CNT_HI);
        wr_p_lo = wr_en && (addr == ADDR_PAIR_LO);
        wr_p_hi = wr_en && (addr == ADDR_PAIR_HI);
        wr_flg  = wr_en && (addr == ADDR_FLAGS);

        c_ld_lo     = wr_c_lo;
        c_ld_hi     = wide_sel ? wr_c_lo : wr_c_hi;
        cnt_ld_val  = wide_sel ? {temp, wdata} : {wdata, wdata};
        p_ld_lo     = wr_p_lo;
        p_ld_hi     = wide_sel ? wr_p_lo : wr_p_hi;
        pair_ld_val = wide_sel ? {temp, wdata} : {wdata, wdata};

        temp_ld  = 1'b0;
        temp_val = wdata;
        if (wide_sel) begin
            if (wr_c_hi || wr_p_hi) begin
                temp_ld  = 1'b1;
                temp_val = wdata;
            end else if (rd_en && !wr_en && addr == ADDR_CNT_LO) begin
                temp_ld  = 1'b1;
                temp_val = cnt[WW-1:DW];
            end else if (rd_en && !wr_en && addr == ADDR_PAIR_LO && cap_mode) begin
                temp_ld  = 1'b1;
                temp_val = pair[WW-1:DW];
            end
        end
    end

    tmr16_tempreg #(.DW(DW)) u_temp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (temp_ld),
        .load_val (temp_val),
        .temp_o   (temp)
    );

    tmr16_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide_sel),
        .cmp_mode (!cap_mode),
        .tick     (tick),
        .ld_lo    (c_ld_lo),
        .ld_hi    (c_ld_hi),
        .ld_val   (cnt_ld_val),
        .top      (pair),
        .cnt_o    (cnt),
        .match_o  (match)
    );

    tmr16_pair #(.DW(DW)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide_sel),
        .cap_mode (cap_mode),
        .cap_evt  (cap_evt),
        .ld_lo    (p_ld_lo),
        .ld_hi    (p_ld_hi),
        .ld_val   (pair_ld_val),
        .cnt      (cnt),
        .pair_o   (pair),
        .capt_o   (capt)
    );

    assign flags_set[FLAG_MATCH] = match;
    assign flags_set[FLAG_CAPT]  = capt;

    generate
        for (genvar b = 0; b < FLAG_N; b++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            flags_q[b] <= 1'b0;
                else if (flags_set[b]) flags_q[b] <= 1'b1;
                else if (wr_flg && wdata[b]) flags_q[b] <= 1'b0;
            end

            // R9
            flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_q[b] && !(wr_flg && wdata[b])) |=> flags_q[b]);
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        case (addr)
            ADDR_CNT_LO:  rd_mux = cnt[DW-1:0];
            ADDR_CNT_HI:  rd_mux = wide_sel ? temp : cnt[WW-1:DW];
            ADDR_PAIR_LO: rd_mux = pair[DW-1:0];
            ADDR_PAIR_HI: rd_mux = (wide_sel && cap_mode) ? temp : pair[WW-1:DW];
            ADDR_FLAGS:   rd_mux = {{(DW-FLAG_N){1'b0}}, flags_q};
            default:      rd_mux = '0;
        endcase
        rdata = rd_en ? rd_mux : '0;
    end

    // R1
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

    // R4
    temp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_sel && rd_en && !wr_en && addr == ADDR_CNT_LO)
            |=> (temp == $past(cnt[WW-1:DW])));

    // R9
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[FLAG_MATCH]) |-> $past(match));
endmodule

// File: tb/tmr16_bridge_tb.sv
module tmr16_bridge_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata;
    logic       wide_sel = 1'b1, cap_mode = 1'b0, cap_evt = 1'b0, tick = 1'b0;

    int n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr16_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .wide_sel(wide_sel), .cap_mode(cap_mode),
        .cap_evt(cap_evt), .tick(tick)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 check(tag, rdata, exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 idle rdata", rdata, 8'h00);
        for (int a = 0; a < 5; a++) rd_chk(a[2:0], 8'h00, "R1 reset value");
    endtask

    task automatic t_wide_write();
        wr(3'd1, 8'h12); wr(3'd0, 8'h34);
        rd_chk(3'd0, 8'h34, "R3 counter low");
        rd_chk(3'd1, 8'h12, "R3 counter high");
        wr(3'd1, 8'h77);
        rd_chk(3'd0, 8'h34, "R2 low unchanged by high write");
        rd_chk(3'd1, 8'h12, "R2 high unchanged by high write");
    endtask

    task automatic t_shared_latch();
        wr(3'd3, 8'hAB); wr(3'd0, 8'h01);
        rd_chk(3'd0, 8'h01, "R5 counter low");
        rd_chk(3'd1, 8'hAB, "R5 high from shared latch");
        rd_chk(3'd3, 8'h00, "R2 pair high untouched");
    endtask

    task automatic t_cmp_direct();
        wr(3'd3, 8'h02); wr(3'd2, 8'h05);
        wr(3'd1, 8'h55); wr(3'd0, 8'h66);
        rd_chk(3'd0, 8'h66, "R6 counter low");
        rd_chk(3'd3, 8'h02, "R6 compare high read direct");
        rd_chk(3'd2, 8'h05, "R6 compare low");
        rd_chk(3'd1, 8'h55, "R6 latch kept by compare reads");
    endtask

    task automatic t_ctc();
        wr(3'd3, 8'h01); wr(3'd2, 8'h03);
        wr(3'd1, 8'h01); wr(3'd0, 8'h01);
        repeat (3) @(negedge clk);
        rd_chk(3'd0, 8'h01, "R8 no count without tick");
        pulse_tick(); pulse_tick();
        rd_chk(3'd0, 8'h03, "R8 reached compare low");
        rd_chk(3'd1, 8'h01, "R8 reached compare high");
        rd_chk(3'd4, 8'h00, "R8 no flag at compare value");
        pulse_tick();
        rd_chk(3'd0, 8'h00, "R8 cleared low");
        rd_chk(3'd1, 8'h00, "R8 cleared high");
        rd_chk(3'd4, 8'h01, "R8 match flag");
        pulse_tick();
        rd_chk(3'd0, 8'h01, "R8 counts after clear");
    endtask

    task automatic t_flag_clear();
        wr(3'd4, 8'h00);
        rd_chk(3'd4, 8'h01, "R9 zero write ignored");
        wr(3'd4, 8'h01);
        rd_chk(3'd4, 8'h00, "R9 one write clears");
    endtask

    task automatic t_collide();
        wr(3'd1, 8'h00);
        @(negedge clk);
        addr = 3'd0; wdata = 8'h40; wr_en = 1'b1; tick = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; tick = 1'b0;
        rd_chk(3'd0, 8'h40, "R10 write beats tick low");
        rd_chk(3'd1, 8'h00, "R10 write beats tick high");
    endtask

    task automatic t_read_latch();
        wr(3'd1, 8'h00); wr(3'd0, 8'hFF);
        rd_chk(3'd0, 8'hFF, "R4 low read");
        pulse_tick();
        rd_chk(3'd1, 8'h00, "R4 high from frozen latch");
        rd_chk(3'd0, 8'h00, "R4 low after carry");
        rd_chk(3'd1, 8'h01, "R4 high after carry");
    endtask

    task automatic t_capture();
        cap_mode = 1'b1;
        wr(3'd1, 8'h22); wr(3'd0, 8'h33);
        @(negedge clk); cap_evt = 1'b1;
        @(posedge clk); #1; cap_evt = 1'b0;
        rd_chk(3'd4, 8'h02, "R7 capture flag");
        wr(3'd1, 8'h50); wr(3'd0, 8'h00);
        rd_chk(3'd2, 8'h33, "R7 captured low");
        rd_chk(3'd3, 8'h22, "R7 captured high via latch");
        rd_chk(3'd2, 8'h33, "R7 captured low again");
        rd_chk(3'd0, 8'h00, "R7 counter low");
        rd_chk(3'd3, 8'h50, "R7 high read returns latch");
        cap_mode = 1'b0;
    endtask

    task automatic t_narrow();
        wr(3'd1, 8'hC3);
        wide_sel = 1'b0;
        wr(3'd0, 8'h05); wr(3'd2, 8'h06); wr(3'd1, 8'h11);
        rd_chk(3'd1, 8'h11, "R11 high direct");
        rd_chk(3'd0, 8'h05, "R11 low direct");
        pulse_tick(); pulse_tick();
        rd_chk(3'd0, 8'h00, "R11 low cleared against A");
        rd_chk(3'd1, 8'h11, "R11 high holds");
        rd_chk(3'd4, 8'h03, "R11 match flag in narrow mode");
        wide_sel = 1'b1;
        rd_chk(3'd1, 8'hC3, "R11 latch untouched in narrow mode");
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide_write();
        t_shared_latch();
        t_cmp_direct();
        t_ctc();
        t_flag_clear();
        t_collide();
        t_read_latch();
        t_capture();
        t_narrow();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule